// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog for a system controller. Software loads a timeout period in ticks and clears a halt bit. It must then keep writing a reload register before the count runs out. The count advances on a single-cycle tick strobe that an external prescaler supplies, nominally about 0.6 s per tick.

When the count runs out for the first time, the block sets a timeout status bit and starts counting again from the programmed period. If that status bit is still set when the count runs out again, the block records a second-timeout status and drives a system reset pulse of fixed length. After the pulse it sets a boot status bit, so that software can see the cause of the restart. A no-reboot bit blocks the reset. That bit can be set by a strap pin or by software, and it always reads back its effective value.

A strap input selects the period width. Legacy mode uses a 6-bit tick count inside an 8-bit register. Extended mode uses a 10-bit tick count inside a 16-bit register. In both modes the bits above the count field are plain storage that software keeps across its writes. The recommended arming order is: set halt, write the period, clear halt, write reload.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the period register reads 0x0004, the control register reads 0x0001 (halt bit 0 set, no-reboot bit 1 clear while the strap is low), the status register reads 0x0000, and `sys_rst` is low.
- R2: In legacy mode (`ext_mode`=0) a write to the period register (address 0) always stores `wdata[7:6]`. It updates the tick field with `wdata[5:0]` only when that value is at least 4. Smaller values leave the field unchanged. Readback is {8'h00, upper bits, field}.
- R3: In extended mode (`ext_mode`=1) a period write always stores `wdata[15:10]`. It updates the 10-bit field with `wdata[9:0]` only when that value is at least 2. Readback is {upper bits, field}.
- R4: While the halt bit (control bit 0, address 2) is set, ticks do not advance the count and cause no expiry.
- R5: Any write to the reload register (address 1), of any value, restarts the count from the programmed period P. With the timer running, the expiry happens on the P-th tick after that write.
- R6: An expiry while the timeout status bit (status bit 0, address 3) is clear sets that bit, leaves `sys_rst` low, and restarts the count from P.
- R7: An expiry while status bit 0 is set sets the second-timeout bit (status bit 1). If reboot is allowed, it also drives `sys_rst` high for exactly RST_CYCLES clock cycles, and then sets the boot bit (status bit 2).
- R8: The no-reboot state is control bit 1 ORed with `noreboot_strap`. Control bit 1 reads back this effective value. When the state is set, a second expiry sets status bit 1 but leaves `sys_rst` low and bit 2 clear.
- R9: Writing 1 to a status bit (bits 0, 1 or 2) clears it. Writing 0 leaves it unchanged. A timer whose bit 0 has been cleared treats its next expiry as a first expiry.
- R10: A period write while the count is running does not change the current countdown. The new period takes effect at the next reload or expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode | input | 1 | Mode strap: 0 selects the 6-bit period, 1 selects the 10-bit period |
| noreboot_strap | input | 1 | Strap that blocks the system reset when high |
| tick | input | 1 | One-cycle prescaled tick strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 period, 1 reload, 2 control, 3 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| sys_rst | output | 1 | System reset pulse |

## Verification
A wrong count value appears only as an expiry on the wrong tick. The bench therefore reads status bit 0 one tick before the expected expiry and again exactly on it, for several periods and in both modes. A wrong second-stage decision appears on the very tick of the second expiry, as a missing or extra reset pulse. The bench checks the pulse length cycle by cycle and reads the full status word right after the pulse. Gating faults in the period range check or in the no-reboot logic show up in the readback of the next read, because the bench reads the registers back immediately after each write.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int CNT_W      = 10,
  parameter int LEG_W      = 6,
  parameter int LEG_MIN    = 4,
  parameter int EXT_MIN    = 2,
  parameter int PERIOD_RST = 4,
  parameter int RST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mode,
  input  logic        noreboot_strap,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        sys_rst
);
  localparam int SPARE_W = 16 - CNT_W;
  localparam int LSPR_W  = 8 - LEG_W;
  localparam int RC_W    = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0]   pfield_q, cnt_q;
  logic [SPARE_W-1:0] spare_q;
  logic               halt_q, nrb_q, tmo_q, sec_q, boot_q;
  logic [RC_W-1:0]    rst_cnt_q;

  wire nrb_eff = nrb_q | noreboot_strap;
  wire [CNT_W-1:0] period = ext_mode ? pfield_q
                          : {{(CNT_W-LEG_W){1'b0}}, pfield_q[LEG_W-1:0]};
  wire [CNT_W-1:0] wr_field = ext_mode ? wdata[CNT_W-1:0]
                            : {{(CNT_W-LEG_W){1'b0}}, wdata[LEG_W-1:0]};
  wire field_ok = wr_field >= (ext_mode ? CNT_W'(EXT_MIN) : CNT_W'(LEG_MIN));

  wire wr_per = wr_en && addr == 2'd0;
  wire wr_rld = wr_en && addr == 2'd1;
  wire wr_ctl = wr_en && addr == 2'd2;
  wire wr_sts = wr_en && addr == 2'd3;

  wire running = tick && !halt_q;
  wire expire  = running && cnt_q <= CNT_W'(1);
  wire second  = expire && tmo_q;

  assign sys_rst = rst_cnt_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfield_q <= CNT_W'(PERIOD_RST);
      spare_q  <= '0;
    end else if (wr_per) begin
      spare_q <= ext_mode ? wdata[15:CNT_W] : SPARE_W'(wdata[7:LEG_W]);
      if (field_ok) pfield_q <= wr_field;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= CNT_W'(PERIOD_RST);
    else if (wr_rld)  cnt_q <= period;
    else if (expire)  cnt_q <= period;
    else if (running) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      nrb_q  <= 1'b0;
    end else if (wr_ctl) begin
      halt_q <= wdata[0];
      nrb_q  <= wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= 1'b0;
      sec_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      if (expire)                 tmo_q  <= 1'b1;
      else if (wr_sts && wdata[0]) tmo_q <= 1'b0;
      if (second)                 sec_q  <= 1'b1;
      else if (wr_sts && wdata[1]) sec_q <= 1'b0;
      if (rst_cnt_q == RC_W'(1))  boot_q <= 1'b1;
      else if (wr_sts && wdata[2]) boot_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               rst_cnt_q <= '0;
    else if (second && !nrb_eff && !sys_rst)  rst_cnt_q <= RC_W'(RST_CYCLES);
    else if (sys_rst)                         rst_cnt_q <= rst_cnt_q - 1'b1;
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = ext_mode ? {spare_q, pfield_q}
                                : {8'h00, spare_q[LSPR_W-1:0], pfield_q[LEG_W-1:0]};
      2'd2:    rdata = {14'd0, nrb_eff, halt_q};
      2'd3:    rdata = {13'd0, boot_q, sec_q, tmo_q};
      default: rdata = 16'h0000;
    endcase
  end
endmodule

module wdog_two_stage_chk #(
  parameter int CNT_W      = 10,
  parameter int RST_CYCLES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic             sys_rst,
  input logic             halt,
  input logic             nrb_eff,
  input logic             tmo,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period
);
  logic        prev_rst;
  logic [15:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rst <= 1'b0;
      hi_len   <= '0;
    end else begin
      prev_rst <= sys_rst;
      if (sys_rst && !prev_rst) hi_len <= 16'd1;
      else if (sys_rst)         hi_len <= hi_len + 16'd1;
    end
  end

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !(wr_en && addr == 2'd1)) |=> $stable(cnt));

  // R5
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (cnt == $past(period)));

  // R7
  rst_needs_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(tmo));

  // R8
  noreboot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> !$past(nrb_eff));

  // R7
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && prev_rst) |-> (hi_len == 16'(RST_CYCLES)));
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .sys_rst(sys_rst),
  .halt(halt_q), .nrb_eff(nrb_eff), .tmo(tmo_q), .cnt(cnt_q), .period(period)
);

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;
  localparam int RST_CYC = 5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ext_mode = 1'b0, noreboot_strap = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0, rdata;
  logic        sys_rst;
  int checks = 0, errors = 0;
  logic saw_rst;

  always #4 clk = ~clk;

  wdog_two_stage #(.RST_CYCLES(RST_CYC)) i_wdog_two_stage (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .noreboot_strap(noreboot_strap),
    .tick(tick), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst(sys_rst)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (sys_rst) saw_rst = 1'b1;
    end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(2'd0, d); chk("R1 period", d, 16'h0004);
    rd(2'd2, d); chk("R1 control", d, 16'h0001);
    rd(2'd3, d); chk("R1 status", d, 16'h0000);
    chk("R1 sys_rst", {15'd0, sys_rst}, 16'h0000);
  endtask

  task automatic t_legacy_period;
    logic [15:0] d;
    wr(2'd0, 16'hFFC5); rd(2'd0, d); chk("R2 legacy write", d, 16'h00C5);
    wr(2'd0, 16'h0082); rd(2'd0, d); chk("R2 too small", d, 16'h0085);
    wr(2'd0, 16'h0005); rd(2'd0, d); chk("R2 rewrite", d, 16'h0005);
  endtask

  task automatic t_halt;
    logic [15:0] d;
    wr(2'd1, 16'h0001);
    ticks(12); rd(2'd3, d); chk("R4 halted", d, 16'h0000);
  endtask

  task automatic t_first;
    logic [15:0] d;
    wr(2'd2, 16'h0000); wr(2'd1, 16'h00A5);
    ticks(4); rd(2'd3, d); chk("R5 before expiry", d, 16'h0000);
    ticks(1); rd(2'd3, d); chk("R6 first expiry", d, 16'h0001);
    chk("R6 no reset", {15'd0, sys_rst}, 16'h0000);
  endtask

  task automatic t_w1c;
    logic [15:0] d;
    wr(2'd3, 16'h0000); rd(2'd3, d); chk("R9 write 0 keeps", d, 16'h0001);
    wr(2'd3, 16'h0001); rd(2'd3, d); chk("R9 write 1 clears", d, 16'h0000);
    wr(2'd1, 16'h0000); saw_rst = 1'b0;
    ticks(5); rd(2'd3, d); chk("R9 cleared acts as first", d, 16'h0001);
    chk("R9 no reset", {15'd0, saw_rst}, 16'h0000);
  endtask

  task automatic t_second;
    logic [15:0] d;
    int n;
    ticks(4); chk("R7 not yet", {15'd0, sys_rst}, 16'h0000);
    ticks(1);
    n = 0;
    while (sys_rst && n < 100) begin n++; @(negedge clk); end
    chk("R7 pulse length", 16'(n), 16'(RST_CYC));
    rd(2'd3, d); chk("R7 status after reset", d, 16'h0007);
    wr(2'd3, 16'h0007); rd(2'd3, d); chk("R9 clear all", d, 16'h0000);
  endtask

  task automatic t_noreboot;
    logic [15:0] d;
    wr(2'd2, 16'h0002); rd(2'd2, d); chk("R8 ctrl readback", d, 16'h0002);
    wr(2'd1, 16'h0000); saw_rst = 1'b0;
    ticks(10);
    chk("R8 reset blocked", {15'd0, saw_rst}, 16'h0000);
    rd(2'd3, d); chk("R8 status", d, 16'h0003);
    wr(2'd3, 16'h0007);
    noreboot_strap = 1'b1;
    wr(2'd2, 16'h0000); rd(2'd2, d); chk("R8 strap forces", d, 16'h0002);
    noreboot_strap = 1'b0;
    rd(2'd2, d); chk("R8 strap released", d, 16'h0000);
  endtask

  task automatic t_period_change;
    logic [15:0] d;
    wr(2'd1, 16'h0000);
    ticks(2);
    wr(2'd0, 16'h003F);
    ticks(2); rd(2'd3, d); chk("R10 old period runs", d, 16'h0000);
    ticks(1); rd(2'd3, d); chk("R10 expiry on old period", d, 16'h0001);
    wr(2'd3, 16'h0001);
    ticks(62); rd(2'd3, d); chk("R10 new period next", d, 16'h0000);
    ticks(1); rd(2'd3, d); chk("R10 new period expiry", d, 16'h0001);
    wr(2'd3, 16'h0007);
  endtask

  task automatic t_extended;
    logic [15:0] d;
    wr(2'd2, 16'h0001);
    ext_mode = 1'b1;
    wr(2'd0, 16'hA658); rd(2'd0, d); chk("R3 ext write", d, 16'hA658);
    wr(2'd0, 16'h0001); rd(2'd0, d); chk("R3 too small", d, 16'h0258);
    wr(2'd0, 16'h0002); rd(2'd0, d); chk("R3 min accepted", d, 16'h0002);
    wr(2'd2, 16'h0000); wr(2'd1, 16'hBEEF);
    ticks(1); rd(2'd3, d); chk("R5 ext before expiry", d, 16'h0000);
    ticks(1); rd(2'd3, d); chk("R5 ext expiry", d, 16'h0001);
    wr(2'd2, 16'h0001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still active, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    saw_rst = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_legacy_period;
    t_halt;
    t_first;
    t_w1c;
    t_second;
    t_noreboot;
    t_period_change;
    t_extended;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule